// File: doc/BRIEF.md
# Four-Bit Accumulating ALU Datapath

This block is a tiny accumulator machine. A four-bit state register feeds the A side of a four-operation ALU. The ALU result is written back into the register, so each update applies the selected operation to the running value. The B side and the two-bit operation select come from outside, for example from board switches. The register value is also decoded to a hexadecimal glyph for a seven-segment digit.

Updates do not happen on every clock. An internal divider produces a one-cycle enable pulse once every `CLK_HZ/STEP_HZ` system clocks, which gives one update per second on a board. A non-zero `SIM_DIV` parameter replaces that period with a short one. Everything stays in a single clock domain, and the asynchronous active-low reset clears both the register and the divider.

Top module: `nibble_accum`

## Requirements
- R1: While `rst_n` is low, `acc_q` is 0 and `seg_n` shows the glyph for 0. The clear takes effect asynchronously, without waiting for a clock edge.
- R2: `acc_q` changes only on a clock edge where the internal update pulse is high. On every other edge it holds its value.
- R3: The update pulse is one clock wide. It occurs on the DIV-th rising edge after reset is released and then on every DIV-th edge after that. DIV is `SIM_DIV` when that is non-zero, otherwise `CLK_HZ/STEP_HZ`.
- R4: Operation select 2'b00 keeps the register value unchanged.
- R5: Operation select 2'b01 adds one to the register value, wrapping from 15 to 0.
- R6: Operation select 2'b10 adds `opnd_b` to the register value modulo 16, and the carry is dropped.
- R7: Operation select 2'b11 loads the bitwise AND of the register value and `opnd_b`.
- R8: Only the `op_sel` and `opnd_b` values present at the update edge matter. Values applied earlier in the interval and then changed have no effect.
- R9: `seg_n` is active low with bit order {g,f,e,d,c,b,a}, bit 0 being segment a. It shows the usual hex glyphs 0-9, A, b, C, d, E, F for `acc_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_b | input | 4 | ALU operand B |
| op_sel | input | 2 | Operation select |
| acc_q | output | 4 | Accumulator register value |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |

## Verification
A new register value is due on the DIV-th rising edge after the operands are applied. One register stands between the operands and `acc_q`, and the decoder adds no further delay. The bench therefore counts rising edges from reset release, compares `acc_q` and `seg_n` 1 ns after every DIV-th edge, and checks on every other edge that the value held. Operands are driven only on falling edges. The operand-timing test changes them two cycles before the update edge, and the reset test compares 1 ns after `rst_n` falls, before any clock edge.

// File: rtl/nibble_accum_pkg.sv
package nibble_accum_pkg;

  localparam int unsigned ACC_W = 4;
  localparam int unsigned SEG_W = 7;

  typedef logic [ACC_W-1:0] nib_t;
  typedef logic [SEG_W-1:0] seg_t;

  typedef enum logic [1:0] {
    OP_KEEP = 2'b00,
    OP_INC  = 2'b01,
    OP_SUM  = 2'b10,
    OP_MASK = 2'b11
  } op_e;

  // ALU arithmetic; the carry out of the adds is dropped
  function automatic nib_t alu_eval(op_e op, nib_t a, nib_t b);
    nib_t y;
    case (op)
      OP_KEEP: y = a;
      OP_INC:  y = a + nib_t'(1);
      OP_SUM:  y = a + b;
      default: y = a & b;
    endcase
    return y;
  endfunction

  // lit segments, active high, order {g,f,e,d,c,b,a}
  function automatic seg_t hex_glyph(nib_t v);
    seg_t s;
    case (v)
      4'h0: s = 7'b0111111;
      4'h1: s = 7'b0000110;
      4'h2: s = 7'b1011011;
      4'h3: s = 7'b1001111;
      4'h4: s = 7'b1100110;
      4'h5: s = 7'b1101101;
      4'h6: s = 7'b1111101;
      4'h7: s = 7'b0000111;
      4'h8: s = 7'b1111111;
      4'h9: s = 7'b1101111;
      4'hA: s = 7'b1110111;
      4'hB: s = 7'b1111100;
      4'hC: s = 7'b0111001;
      4'hD: s = 7'b1011110;
      4'hE: s = 7'b1111001;
      default: s = 7'b1110001;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/acc_tick_gen.sv
module acc_tick_gen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic step
);
  generate
    if (DIV <= 1) begin : g_every
      assign step = rst_n;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      assign step = (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (step) cnt <= '0;
        else           cnt <= cnt + CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import nibble_accum_pkg::*;
(
  input  op_e  op,
  input  nib_t a,
  input  nib_t b,
  output nib_t y
);
  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/acc_reg.sv
module acc_reg
  import nibble_accum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  nib_t d,
  output nib_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/acc_seg7.sv
module acc_seg7
  import nibble_accum_pkg::*;
(
  input  nib_t val,
  output seg_t seg_n
);
  assign seg_n = ~hex_glyph(val);
endmodule

// File: rtl/nibble_accum.sv
module nibble_accum
  import nibble_accum_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned STEP_HZ = 1,
  parameter int unsigned SIM_DIV = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opnd_b,
  input  logic [1:0] op_sel,
  output logic [3:0] acc_q,
  output logic [6:0] seg_n
);
  localparam int unsigned DIV = (SIM_DIV != 0) ? SIM_DIV : (CLK_HZ / STEP_HZ);

  logic step;
  nib_t alu_y;
  nib_t state_q;
  op_e  op;

  assign op = op_e'(op_sel);

  acc_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step)
  );

  acc_alu u_alu (
    .op (op),
    .a  (state_q),
    .b  (opnd_b),
    .y  (alu_y)
  );

  acc_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step),
    .d     (alu_y),
    .q     (state_q)
  );

  acc_seg7 u_seg (
    .val   (state_q),
    .seg_n (seg_n)
  );

  assign acc_q = state_q;
endmodule

// File: rtl/nibble_accum_chk.sv
module nibble_accum_chk #(
  parameter int unsigned DIV = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       step,
  input logic [1:0] op_sel,
  input logic [3:0] opnd_b,
  input logic [3:0] acc_q,
  input logic [6:0] seg_n
);
  localparam int unsigned GW = (DIV > 1) ? $clog2(DIV) + 1 : 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap <= '0;
    else if (step) gap <= '0;
    else           gap <= gap + GW'(1);
  end

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> acc_q == 4'h0);
  a_r2_hold_off_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_q));
  a_r3_step_period: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (32'(gap) == DIV - 1));
  a_r3_step_due: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(gap) == DIV - 1) |-> step);
  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op_sel == 2'b00) |=> acc_q == $past(acc_q));
  a_r5_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op_sel == 2'b01) |=> acc_q == 4'($past(acc_q) + 4'd1));
  a_r6_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op_sel == 2'b10) |=> acc_q == 4'($past(acc_q) + $past(opnd_b)));
  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op_sel == 2'b11) |=> acc_q == ($past(acc_q) & $past(opnd_b)));
  a_r9_glyph_lit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~seg_n) >= 2);
  a_r9_eight_full: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q == 4'h8 |-> seg_n == 7'h00);
endmodule

bind nibble_accum nibble_accum_chk #(.DIV(DIV)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .step   (step),
  .op_sel (op_sel),
  .opnd_b (opnd_b),
  .acc_q  (acc_q),
  .seg_n  (seg_n)
);

// File: tb/sim_nibble_accum.sv
`timescale 1ns/1ps
module sim_nibble_accum;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opnd_b = 4'h0;
  logic [1:0] op_sel = 2'b00;
  logic [3:0] acc_q;
  logic [6:0] seg_n;

  always #2 clk = ~clk;

  nibble_accum #(.SIM_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .opnd_b(opnd_b), .op_sel(op_sel),
    .acc_q(acc_q), .seg_n(seg_n)
  );

  typedef struct { logic [3:0] val; string req; } item_t;
  item_t exp_q[$];

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] model = 4'h0;
  logic [3:0] shown = 4'h0;
  bit done = 0;

  function automatic logic [6:0] glyph_n(logic [3:0] v);
    logic [6:0] on [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return ~on[v];
  endfunction

  function automatic logic [3:0] ref_op(logic [1:0] op, logic [3:0] a, logic [3:0] b);
    int r;
    if (op == 2'd0)      r = a;
    else if (op == 2'd1) r = (a + 1) % 16;
    else if (op == 2'd2) r = (a + b) % 16;
    else                 r = a & b;
    return 4'(r);
  endfunction

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: counts edges from reset release and pops at each update edge
  int cyc = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      shown = 4'h0;
    end else if (!done) begin
      cyc++;
      if (cyc == DIV) begin
        item_t it;
        cyc = 0;
        it.val = shown;
        it.req = "R4";
        if (exp_q.size() > 0) it = exp_q.pop_front();
        shown = it.val;
        #1;
        chk(it.req, 7'(acc_q), 7'(it.val));
        chk("R9", seg_n, glyph_n(it.val));
      end else begin
        #1;
        chk("R2", 7'(acc_q), 7'(shown));
      end
    end
  end

  // driver: called on a falling edge, returns on the falling edge after the update
  task automatic drive(logic [1:0] op, logic [3:0] b, string req, bit decoy);
    item_t it;
    it.val = ref_op(op, model, b);
    it.req = req;
    model = it.val;
    exp_q.push_back(it);
    if (decoy) begin
      op_sel = ~op;
      opnd_b = ~b;
      repeat (DIV - 2) @(negedge clk);
      op_sel = op;
      opnd_b = b;
      repeat (2) @(negedge clk);
    end else begin
      op_sel = op;
      opnd_b = b;
      repeat (DIV) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: state during reset
    repeat (3) @(negedge clk);
    chk("R1", 7'(acc_q), 7'h0);
    chk("R1", seg_n, glyph_n(4'h0));
    rst_n = 1'b1;
    // R3: first update lands on the DIV-th edge, checked by the monitor timing
    drive(2'b01, 4'h0, "R3", 0);
    for (int i = 0; i < 16; i++) drive(2'b01, 4'h0, "R5", 0);
    drive(2'b00, 4'hF, "R4", 0);
    drive(2'b10, 4'h9, "R6", 0);
    drive(2'b10, 4'hC, "R6", 0);
    drive(2'b10, 4'h0, "R6", 0);
    drive(2'b11, 4'h6, "R7", 0);
    drive(2'b11, 4'hF, "R7", 0);
    drive(2'b10, 4'hB, "R6", 0);
    drive(2'b11, 4'h9, "R7", 0);
    drive(2'b10, 4'h5, "R8", 1);
    drive(2'b00, 4'h3, "R8", 1);
    drive(2'b01, 4'h7, "R8", 1);
    for (int v = 0; v < 16; v++) drive(2'b10, 4'(v == 0 ? 0 : 1), "R9", 0);
    drive(2'b10, 4'h7, "R6", 0);
    // R1: asynchronous clear in mid-interval
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", 7'(acc_q), 7'h0);
    chk("R1", seg_n, glyph_n(4'h0));
    model = 4'h0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(2'b10, 4'h4, "R3", 0);
    drive(2'b01, 4'h0, "R5", 0);
    finish_run();
  end
endmodule